// File: doc/BRIEF.md
# Debug Event Recorder with Delayed Interrupt

This block keeps a small debug status register and decides when a debug interrupt request goes to the core. It watches two event sources. One is an unconditional debug input that has no enable of its own. The other is a return-type debug event, reported in the cycle a return-from-interrupt executes. Every event is recorded, whatever the state of the debug-enable bit. Whether it interrupts at once, later or never depends on that bit, on a higher-priority exception flag and on what software clears in the meantime.

An event that finds debug interrupts enabled raises the request at once. The saved address is then the address of the instruction that would have run next. An event that arrives while debug interrupts are disabled is still recorded and stays pending. It fires later, when debug-enable becomes set, and the saved address is then the address after the instruction that set the enable. An imprecise flag in the status register lets handler software tell the two meanings apart. Once raised, the request is held until the core acknowledges it. The block then asks for debug-enable to be cleared.

All interfaces are plain control and status pins. The only data flowing in is the next-instruction address, sampled when an interrupt is taken. The status clear port is a write strobe with a mask, and it is never stalled. No valid/ready back-pressure applies.

Top module: `dbg_evt_ctrl`

## Requirements
- R1: After reset, `status_o` is 000, and `irq_req_o`, `de_clr_o` and `save_addr_o` are zero.
- R2: An unconditional event (`uncond_evt_i` high) sets status bit 0 on the next clock, whatever the value of `dbg_en_i`.
- R3: An unconditional event with `dbg_en_i`=1, `hipri_i`=0 and no request already raised sets `irq_req_o` on the next clock. `save_addr_o` then holds the `next_addr_i` value from the event cycle.
- R4: An unconditional event with `dbg_en_i`=0 sets status bit 2 (the imprecise flag) and does not raise `irq_req_o`.
- R5: A held event fires in the first cycle where `dbg_en_i` or `de_set_i` is high, `hipri_i` is low and no request is raised. `save_addr_o` takes `next_addr_i` of that cycle, which is the address after the instruction that set debug-enable.
- R6: While `hipri_i` is high, no request is raised. An event blocked this way is held and fires under the rule of R5.
- R7: Writing `clr_we_i`=1 clears every status bit whose `clr_mask_i` bit is 1, on the next clock. A bit that is being set in the same cycle stays set.
- R8: A clear that leaves status bits 0 and 1 both zero cancels any held event, so a later debug-enable raises no request.
- R9: A return event (`ret_evt_i`) with `dbg_en_i`=0 sets status bits 1 and 2, raises no request, and is held.
- R10: A return event with `dbg_en_i`=1 but `ret_de_after_i`=0 (the return leaves debug-enable clear) sets status bit 1 but not bit 2, raises no request, and is held.
- R11: A return event with `dbg_en_i`=1 and `ret_de_after_i`=1 raises the request on the next clock, with `save_addr_o` taken from that cycle.
- R12: `irq_req_o` stays high until a cycle with `irq_ack_i`=1. On the next clock it drops, and `de_clr_o` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uncond_evt_i | input | 1 | Unconditional debug event pulse |
| ret_evt_i | input | 1 | Return-type debug event pulse, in the cycle the return executes |
| ret_de_after_i | input | 1 | Debug-enable value the executing return leaves behind |
| dbg_en_i | input | 1 | Current debug-enable bit |
| de_set_i | input | 1 | Strobe: an instruction is setting debug-enable this cycle |
| next_addr_i | input | ADDR_W | Address of the next instruction to execute |
| hipri_i | input | 1 | A higher-priority exception is being taken |
| clr_we_i | input | 1 | Status write-one-to-clear strobe |
| clr_mask_i | input | 3 | Bits to clear: 0 unconditional, 1 return, 2 imprecise |
| irq_ack_i | input | 1 | Core acknowledges the debug interrupt |
| irq_req_o | output | 1 | Debug interrupt request |
| save_addr_o | output | ADDR_W | Saved return address for the handler |
| de_clr_o | output | 1 | One-cycle request to clear debug-enable |
| status_o | output | 3 | Status: bit 0 unconditional, bit 1 return, bit 2 imprecise |

## Verification
The unconditional event is driven with debug interrupts enabled, disabled, and blocked by a higher-priority exception. These three cases separate immediate firing, delayed firing on the enable strobe, and firing once the block is lifted. The return event is driven with the enable clear before the return, cleared by the return, and kept set across it. These cases separate setting and not setting the imprecise flag, and holding versus firing at once. Other patterns clear only some of the event bits before the enable arrives, set and clear a bit in the same cycle, and send an event while a request is already raised. These show cancellation, the priority of a set over a clear, and a held second event firing after the acknowledge.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int STAT_W  = 3;
  localparam int UNC_BIT = 0;
  localparam int RTN_BIT = 1;
  localparam int IMP_BIT = 2;
endpackage

// File: rtl/dbg_evt_classify.sv
module dbg_evt_classify
  import dbg_evt_pkg::*;
(
  input  logic              uncond_evt_i,
  input  logic              ret_evt_i,
  input  logic              ret_de_after_i,
  input  logic              dbg_en_i,
  output logic [STAT_W-1:0] set_vec_o,
  output logic              imm_hit_o,
  output logic              any_evt_o
);
  always_comb begin
    set_vec_o          = '0;
    set_vec_o[UNC_BIT] = uncond_evt_i;
    set_vec_o[RTN_BIT] = ret_evt_i;
    // imprecise: recorded while debug interrupts were off
    set_vec_o[IMP_BIT] = (uncond_evt_i | ret_evt_i) & ~dbg_en_i;
    imm_hit_o = (uncond_evt_i & dbg_en_i) |
                (ret_evt_i & dbg_en_i & ret_de_after_i);
    any_evt_o = uncond_evt_i | ret_evt_i;
  end
endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status
  import dbg_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  output logic [STAT_W-1:0] stat_q_o,
  output logic              evt_live_o
);
  logic [STAT_W-1:0] stat_d;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    assign stat_d[i] = set_vec_i[i] | (stat_q_o[i] & ~(clr_we_i & clr_mask_i[i]));
    always_ff @(posedge clk) begin
      if (!rst_n) stat_q_o[i] <= 1'b0;
      else        stat_q_o[i] <= stat_d[i];
    end
  end

  assign evt_live_o = stat_d[UNC_BIT] | stat_d[RTN_BIT];
endmodule

// File: rtl/dbg_evt_irq_seq.sv
module dbg_evt_irq_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imm_hit_i,
  input  logic              any_evt_i,
  input  logic              evt_live_i,
  input  logic              dbg_en_i,
  input  logic              de_set_i,
  input  logic              hipri_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic              irq_ack_i,
  output logic              irq_req_o,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic              de_clr_o
);
  logic pend_q;
  logic en_eff;
  logic take;

  assign en_eff = dbg_en_i | de_set_i;
  assign take   = ~irq_req_o & ~hipri_i &
                  (imm_hit_i | (pend_q & en_eff & evt_live_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      irq_req_o   <= 1'b0;
      save_addr_o <= '0;
      de_clr_o    <= 1'b0;
    end else begin
      de_clr_o <= irq_req_o & irq_ack_i;
      if (take) begin
        irq_req_o   <= 1'b1;
        save_addr_o <= next_addr_i;
        pend_q      <= 1'b0;
      end else begin
        pend_q <= (pend_q | any_evt_i) & evt_live_i;
        if (irq_req_o && irq_ack_i) irq_req_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_evt_ctrl.sv
module dbg_evt_ctrl
  import dbg_evt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uncond_evt_i,
  input  logic              ret_evt_i,
  input  logic              ret_de_after_i,
  input  logic              dbg_en_i,
  input  logic              de_set_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic              hipri_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  input  logic              irq_ack_i,
  output logic              irq_req_o,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic              de_clr_o,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] set_vec;
  logic              imm_hit;
  logic              any_evt;
  logic              evt_live;

  dbg_evt_classify u_cls (
    .uncond_evt_i   (uncond_evt_i),
    .ret_evt_i      (ret_evt_i),
    .ret_de_after_i (ret_de_after_i),
    .dbg_en_i       (dbg_en_i),
    .set_vec_o      (set_vec),
    .imm_hit_o      (imm_hit),
    .any_evt_o      (any_evt)
  );

  dbg_evt_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec_i  (set_vec),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .stat_q_o   (status_o),
    .evt_live_o (evt_live)
  );

  dbg_evt_irq_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .imm_hit_i   (imm_hit),
    .any_evt_i   (any_evt),
    .evt_live_i  (evt_live),
    .dbg_en_i    (dbg_en_i),
    .de_set_i    (de_set_i),
    .hipri_i     (hipri_i),
    .next_addr_i (next_addr_i),
    .irq_ack_i   (irq_ack_i),
    .irq_req_o   (irq_req_o),
    .save_addr_o (save_addr_o),
    .de_clr_o    (de_clr_o)
  );
endmodule

// File: rtl/dbg_evt_chk.sv
module dbg_evt_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uncond_evt_i,
  input logic              ret_evt_i,
  input logic              dbg_en_i,
  input logic              de_set_i,
  input logic [ADDR_W-1:0] next_addr_i,
  input logic              hipri_i,
  input logic              irq_ack_i,
  input logic              irq_req_o,
  input logic [ADDR_W-1:0] save_addr_o,
  input logic              de_clr_o,
  input logic [2:0]        status_o
);
  assert_unc_rec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uncond_evt_i |=> status_o[0]);

  assert_save_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req_o) |-> save_addr_o == $past(next_addr_i));

  assert_imp_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uncond_evt_i && !dbg_en_i) |=> status_o[2]);

  assert_no_fire_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req_o && !dbg_en_i && !de_set_i) |=> !irq_req_o);

  assert_hipri_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req_o && hipri_i) |=> !irq_req_o);

  assert_ret_no_imp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_evt_i && dbg_en_i && !uncond_evt_i && !status_o[2]) |=> !status_o[2]);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !irq_ack_i) |=> irq_req_o);

  assert_ack_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_ack_i) |=> (!irq_req_o && de_clr_o));

  assert_declr_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    de_clr_o |=> !de_clr_o);
endmodule

bind dbg_evt_ctrl dbg_evt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .uncond_evt_i (uncond_evt_i),
  .ret_evt_i    (ret_evt_i),
  .dbg_en_i     (dbg_en_i),
  .de_set_i     (de_set_i),
  .next_addr_i  (next_addr_i),
  .hipri_i      (hipri_i),
  .irq_ack_i    (irq_ack_i),
  .irq_req_o    (irq_req_o),
  .save_addr_o  (save_addr_o),
  .de_clr_o     (de_clr_o),
  .status_o     (status_o)
);

// File: tb/tb_dbg_evt_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_evt_ctrl;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          uncond_evt_i = 0, ret_evt_i = 0, ret_de_after_i = 0;
  logic          dbg_en_i = 0, de_set_i = 0, hipri_i = 0;
  logic [AW-1:0] next_addr_i = '0;
  logic          clr_we_i = 0;
  logic [2:0]    clr_mask_i = '0;
  logic          irq_ack_i = 0;
  logic          irq_req_o, de_clr_o;
  logic [AW-1:0] save_addr_o;
  logic [2:0]    status_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [AW-1:0] exp_q[$];
  logic prev_req = 1'b0;

  always #2.5 clk = ~clk;

  dbg_evt_ctrl #(.ADDR_W(AW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_stat(input logic [2:0] e, input string tag);
    chk(status_o == e, tag, {29'd0, status_o}, {29'd0, e});
  endtask

  task automatic chk_req(input logic e, input string tag);
    chk(irq_req_o == e, tag, {31'd0, irq_req_o}, {31'd0, e});
  endtask

  task automatic clear(input logic [2:0] m);
    clr_we_i = 1; clr_mask_i = m;
    tick();
    clr_we_i = 0; clr_mask_i = '0;
  endtask

  task automatic ack_irq();
    irq_ack_i = 1;
    tick();
    irq_ack_i = 0;
    chk_req(1'b0, "R12 req drop on ack");
    chk(de_clr_o == 1'b1, "R12 de_clr pulse", {31'd0, de_clr_o}, 32'd1);
    dbg_en_i = 0;
    tick();
    chk(de_clr_o == 1'b0, "R12 de_clr one cycle", {31'd0, de_clr_o}, 32'd0);
  endtask

  // monitor: each rising request pops one expected saved address
  always @(negedge clk) begin
    if (rst_n && irq_req_o && !prev_req) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected request", save_addr_o, 32'hFFFF_FFFF);
      else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        chk(save_addr_o == e, "R3/R5 saved address", save_addr_o, e);
      end
    end
    prev_req <= irq_req_o;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk_stat(3'b000, "R1 reset status");
    chk_req(1'b0, "R1 reset req");
    chk(save_addr_o == '0, "R1 reset save", save_addr_o, 0);
    chk(de_clr_o == 1'b0, "R1 reset de_clr", {31'd0, de_clr_o}, 0);
    rst_n = 1;
    tick();

    // R3 immediate
    dbg_en_i = 1; uncond_evt_i = 1; next_addr_i = 32'h100; exp_q.push_back(32'h100);
    tick();
    uncond_evt_i = 0;
    chk_req(1'b1, "R3 immediate req");
    chk_stat(3'b001, "R2 uncond bit enabled");
    repeat (3) tick();
    chk_req(1'b1, "R12 req held");
    ack_irq();
    clear(3'b001);
    chk_stat(3'b000, "R7 w1c clear");

    // R4 / R5 delayed
    uncond_evt_i = 1; next_addr_i = 32'h200;
    tick();
    uncond_evt_i = 0;
    chk_stat(3'b101, "R4 imprecise flag");
    chk_req(1'b0, "R4 no req while off");
    repeat (2) tick();
    chk_req(1'b0, "R4 still held");
    de_set_i = 1; next_addr_i = 32'h300; exp_q.push_back(32'h300);
    tick();
    de_set_i = 0; dbg_en_i = 1;
    chk_req(1'b1, "R5 delayed fire");
    ack_irq();
    clear(3'b101);

    // R6 higher priority
    dbg_en_i = 1; hipri_i = 1; uncond_evt_i = 1; next_addr_i = 32'h400;
    tick();
    uncond_evt_i = 0;
    chk_req(1'b0, "R6 blocked");
    tick();
    chk_req(1'b0, "R6 still blocked");
    hipri_i = 0; next_addr_i = 32'h404; exp_q.push_back(32'h404);
    tick();
    chk_req(1'b1, "R6 fire after block");
    ack_irq();
    clear(3'b001);

    // R8 cancel
    uncond_evt_i = 1; next_addr_i = 32'h500;
    tick();
    uncond_evt_i = 0;
    chk_stat(3'b101, "R8 setup");
    clear(3'b001);
    chk_stat(3'b100, "R8 event bit cleared");
    de_set_i = 1;
    tick();
    de_set_i = 0; dbg_en_i = 1;
    chk_req(1'b0, "R8 cancelled no req");
    tick();
    chk_req(1'b0, "R8 cancelled still none");
    dbg_en_i = 0;
    clear(3'b100);

    // R7 set wins over clear
    uncond_evt_i = 1; clr_we_i = 1; clr_mask_i = 3'b001;
    tick();
    uncond_evt_i = 0; clr_we_i = 0; clr_mask_i = '0;
    chk_stat(3'b101, "R7 set wins");
    clear(3'b101);
    chk_stat(3'b000, "R7 cleared");

    // R9 return with enable off
    ret_evt_i = 1; ret_de_after_i = 1;
    tick();
    ret_evt_i = 0;
    chk_stat(3'b110, "R9 return bits");
    chk_req(1'b0, "R9 no req");
    de_set_i = 1; next_addr_i = 32'h600; exp_q.push_back(32'h600);
    tick();
    de_set_i = 0; dbg_en_i = 1;
    chk_req(1'b1, "R9 delayed fire");
    ack_irq();
    clear(3'b110);

    // R10 return leaves enable clear
    dbg_en_i = 1; ret_evt_i = 1; ret_de_after_i = 0;
    tick();
    ret_evt_i = 0; dbg_en_i = 0;
    chk_stat(3'b010, "R10 no imprecise");
    chk_req(1'b0, "R10 no req");
    tick();
    chk_req(1'b0, "R10 held");
    de_set_i = 1; next_addr_i = 32'h700; exp_q.push_back(32'h700);
    tick();
    de_set_i = 0; dbg_en_i = 1;
    chk_req(1'b1, "R10 later fire");
    ack_irq();
    clear(3'b010);

    // R11 return immediate
    dbg_en_i = 1; ret_evt_i = 1; ret_de_after_i = 1; next_addr_i = 32'h800;
    exp_q.push_back(32'h800);
    tick();
    ret_evt_i = 0;
    chk_req(1'b1, "R11 immediate");
    chk_stat(3'b010, "R11 status");
    ack_irq();
    clear(3'b010);

    // R12 / R5 event during active request
    dbg_en_i = 1; uncond_evt_i = 1; next_addr_i = 32'h900; exp_q.push_back(32'h900);
    tick();
    next_addr_i = 32'h904;
    tick();
    uncond_evt_i = 0;
    chk(save_addr_o == 32'h900, "R12 save stable", save_addr_o, 32'h900);
    ack_irq();
    chk_req(1'b0, "R5 held while off");
    de_set_i = 1; next_addr_i = 32'h910; exp_q.push_back(32'h910);
    tick();
    de_set_i = 0; dbg_en_i = 1;
    chk_req(1'b1, "R5 second event fires");
    ack_irq();
    clear(3'b001);
    tick();

    chk(exp_q.size() == 0, "R3 all expected requests seen", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule